// File: doc/BRIEF.md
# Mode-Banked Register File with Exception Entry Sequencer

This block holds the sixteen 32-bit architectural registers of a small RISC core and keeps separate physical copies of some of them for each processor mode. Registers 0 to 14 live in a physical store. Register 15 is the program counter and is held in its own flop. Every register access, whether a read or a write, is resolved through the current mode's bank map. The fast-interrupt mode gets private copies of registers 8 to 14. The normal-interrupt, supervisor, abort and undefined modes each get private copies of registers 13 and 14 only. The status word keeps the mode in bits [2:0], the FIQ mask in bit 6 and the IRQ mask in bit 7. Each non-user mode also has a saved-status register.

The exception sequencer is a two-state machine. In `ST_RUN`, a request that survives masking and priority is accepted. On that edge the sequencer latches the exception kind and a link value, and moves to `ST_TAKE`. In `ST_TAKE`, it commits the entry in one edge and always returns to `ST_RUN`. On the commit edge it:
- saves the old status word into the new mode's saved-status register,
- switches mode and sets the mask bits,
- writes the link value into the new mode's register 14,
- loads the program counter with the exception's vector.

A return, accepted only in `ST_RUN`, restores the status word from the current mode's saved-status register. On the same edge it loads the program counter with register 14 minus a handler-chosen number of words.

Top module: `mode_banked_regfile`

## Requirements
- R1: After reset the program counter is 0, the status word is 0x000000C3 (supervisor mode 3, both masks set), and every register and saved-status register reads 0.
- R2: Two combinational read ports return the register that the current mode's bank map selects. Address 15 returns the program counter. A write to an address other than 15 updates the mapped register at the next edge, in every sequencer state.
- R3: In mode 1 (fast interrupt), addresses 8 to 14 reach private copies. Addresses 0 to 7 reach the user copies.
- R4: In modes 2 (IRQ), 3 (supervisor), 4 (abort) and 5 (undefined), only addresses 13 and 14 are private. Addresses 0 to 12 reach the user copies. Mode 0 (user) and mode codes 6 and 7 use the user copies and have no saved status.
- R5: A register write in the `ST_TAKE` cycle lands in the bank of the mode that was active before the switch. If it targets the same physical register as the link write, the link value wins.
- R6: An accepted request in `ST_RUN` moves the sequencer to `ST_TAKE` on the next edge, and `ST_TAKE` always returns to `ST_RUN`. At the end of `ST_TAKE` the program counter becomes 4 times the request bit index, and the mode becomes the target mode:
  - bit 0 (reset) and bit 2 (software interrupt) go to mode 3;
  - bit 1 (undefined) goes to mode 5;
  - bits 3 (prefetch abort) and 4 (data abort) go to mode 4;
  - bit 6 (IRQ) goes to mode 2;
  - bit 7 (FIQ) goes to mode 1.
- R7: On entry, the old status word is copied into the new mode's saved-status register, bit 7 is set, and bit 6 is also set when entering for FIQ. The other status bits are kept. `saved_status_out` shows the current mode's saved-status register, or 0 when the mode has none.
- R8: The link value written to the new mode's register 14 is the program counter at acceptance plus 8 for IRQ, FIQ and data abort. It is the program counter plus 4 for every other request.
- R9: Priority is reset, data abort, FIQ, IRQ, prefetch abort, undefined, then software interrupt. IRQ is ignored while bit 7 is set and FIQ while bit 6 is set. Request bit 5 is always ignored, and so are all requests seen in `ST_TAKE`.
- R10: A return in `ST_RUN` with no accepted request, in a mode that has a saved-status register, loads the status word from that register. On the same edge it sets the program counter to that mode's register 14 minus 4 times `ret_words`, and the next access uses the restored mode's bank. In any other mode a return has no effect.
- R11: The program counter is updated with this priority:
  1. the vector load on commit;
  2. holding its value in the accept cycle;
  3. the return;
  4. a write to address 15;
  5. a `pc_step` increment of 4.
- R12: A status write replaces the whole status word only in a `ST_RUN` cycle that neither accepts a request nor performs a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_addr_a | input | 4 | Read port A address |
| rd_data_a | output | DATA_W | Read port A data |
| rd_addr_b | input | 4 | Read port B address |
| rd_data_b | output | DATA_W | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DATA_W | Register write data |
| pc_step | input | 1 | Advance program counter by 4 |
| status_wr_en | input | 1 | Status word write enable |
| status_wr_data | input | DATA_W | New status word |
| exc_req | input | 8 | Exception requests, one bit per vector slot |
| exc_ret | input | 1 | Return from exception |
| ret_words | input | 2 | Words subtracted from register 14 on return |
| pc_out | output | DATA_W | Program counter |
| status_out | output | DATA_W | Status word |
| saved_status_out | output | DATA_W | Current mode's saved-status register |

## Verification
The main function is exercised in four ways:
- **Single requests from user mode**, for FIQ, IRQ and software interrupt. Each separates the vector, the target bank and the link offset of one exception kind.
- **Simultaneous requests.** Several bits raised in one cycle, including masked and reserved ones, show whether the priority chain and the masks pick the right winner.
- **Register write in the commit cycle.** A write in the same cycle as the mode switch distinguishes old-bank from new-bank routing.
- **Returns with different word counts.** These confirm that each link value leads back to the intended instruction.

A long constrained-random run then mixes writes, status writes, pulses on several request bits and returns in every mode, and compares against a bench model cycle by cycle.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
    localparam int ARCH_REGS  = 16;
    localparam int ADDR_W     = $clog2(ARCH_REGS);
    localparam int PC_ADDR    = ARCH_REGS - 1;
    localparam int SP_ADDR    = 13;
    localparam int LR_ADDR    = 14;
    localparam int FIQ_LO     = 8;
    localparam int FIQ_BANK_N = PC_ADDR - FIQ_LO;
    localparam int PAIR_MODES = 4;
    localparam int FIQ_BASE   = PC_ADDR;
    localparam int PAIR_BASE  = FIQ_BASE + FIQ_BANK_N;
    localparam int PHYS_N     = PAIR_BASE + 2 * PAIR_MODES;
    localparam int PHYS_W     = $clog2(PHYS_N);
    localparam int SAVED_N    = 5;
    localparam int EXC_N      = 8;
    localparam int BIT_FMASK  = 6;
    localparam int BIT_IMASK  = 7;

    localparam logic [2:0] MD_USR = 3'd0;
    localparam logic [2:0] MD_FIQ = 3'd1;
    localparam logic [2:0] MD_IRQ = 3'd2;
    localparam logic [2:0] MD_SVC = 3'd3;
    localparam logic [2:0] MD_ABT = 3'd4;
    localparam logic [2:0] MD_UND = 3'd5;

    typedef enum logic [2:0] {
        EX_RESET = 3'd0,
        EX_UNDEF = 3'd1,
        EX_SWI   = 3'd2,
        EX_PABT  = 3'd3,
        EX_DABT  = 3'd4,
        EX_RSVD  = 3'd5,
        EX_IRQ   = 3'd6,
        EX_FIQ   = 3'd7
    } exc_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_TAKE = 1'b1
    } seq_e;

    function automatic logic [2:0] exc_target_mode(exc_e k);
        logic [2:0] m;
        case (k)
            EX_UNDEF:         m = MD_UND;
            EX_PABT, EX_DABT: m = MD_ABT;
            EX_IRQ:           m = MD_IRQ;
            EX_FIQ:           m = MD_FIQ;
            default:          m = MD_SVC;
        endcase
        return m;
    endfunction

    // PC already moved past the current instruction when taken
    function automatic logic exc_pc_advanced(exc_e k);
        return (k == EX_IRQ) || (k == EX_FIQ) || (k == EX_DABT);
    endfunction
endpackage

// File: rtl/bank_xlate.sv
module bank_xlate
    import bankrf_pkg::*;
(
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [PHYS_W-1:0] idx
);
    int a_i;
    int m_i;
    int t_i;

    always_comb begin
        a_i = int'(addr);
        m_i = int'(mode);
        t_i = a_i;
        if (a_i == PC_ADDR) begin
            t_i = 0;
        end else if (m_i == int'(MD_FIQ) && a_i >= FIQ_LO) begin
            t_i = FIQ_BASE + a_i - FIQ_LO;
        end else if (m_i >= int'(MD_IRQ) && m_i <= int'(MD_UND) && a_i >= SP_ADDR) begin
            t_i = PAIR_BASE + 2 * (m_i - int'(MD_IRQ)) + (a_i - SP_ADDR);
        end
        idx = PHYS_W'(t_i);
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import bankrf_pkg::*;
(
    input  logic [EXC_N-1:0] req,
    input  logic             irq_mask,
    input  logic             fiq_mask,
    output logic             valid,
    output exc_e             kind
);
    logic [EXC_N-1:0] live;

    always_comb begin
        live = req;
        live[int'(EX_RSVD)] = 1'b0;
        if (irq_mask) live[int'(EX_IRQ)] = 1'b0;
        if (fiq_mask) live[int'(EX_FIQ)] = 1'b0;
        valid = |live;
        if      (live[int'(EX_RESET)]) kind = EX_RESET;
        else if (live[int'(EX_DABT)])  kind = EX_DABT;
        else if (live[int'(EX_FIQ)])   kind = EX_FIQ;
        else if (live[int'(EX_IRQ)])   kind = EX_IRQ;
        else if (live[int'(EX_PABT)])  kind = EX_PABT;
        else if (live[int'(EX_UNDEF)]) kind = EX_UNDEF;
        else                           kind = EX_SWI;
    end
endmodule

// File: rtl/phys_store.sv
module phys_store
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NRD    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NRD-1:0][PHYS_W-1:0]   rd_idx,
    output logic [NRD-1:0][DATA_W-1:0]   rd_data,
    input  logic                         we_a,
    input  logic [PHYS_W-1:0]            wa_idx,
    input  logic [DATA_W-1:0]            wd_a,
    input  logic                         we_b,
    input  logic [PHYS_W-1:0]            wb_idx,
    input  logic [DATA_W-1:0]            wd_b
);
    logic [DATA_W-1:0] mem [PHYS_N];

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = (rd_idx[g] < PHYS_W'(PHYS_N)) ? mem[rd_idx[g]] : '0;
    end

    // port B (link write) is applied last so it wins a collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_N; i++) mem[i] <= '0;
        end else begin
            if (we_a) mem[wa_idx] <= wd_a;
            if (we_b) mem[wb_idx] <= wd_b;
        end
    end
endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [3:0]        rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pc_step,
    input  logic              status_wr_en,
    input  logic [DATA_W-1:0] status_wr_data,
    input  logic [7:0]        exc_req,
    input  logic              exc_ret,
    input  logic [1:0]        ret_words,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] status_out,
    output logic [DATA_W-1:0] saved_status_out
);
    localparam int NRD = 3;
    localparam int LR_PORT = 2;
    localparam logic [DATA_W-1:0] RESET_STATUS =
        DATA_W'((1 << BIT_IMASK) | (1 << BIT_FMASK) | int'(MD_SVC));

    seq_e              state_q, state_d;
    logic [DATA_W-1:0] pc_q, status_q, link_q;
    logic [DATA_W-1:0] saved_q [SAVED_N];
    exc_e              kind_q;

    logic [2:0]        cur_mode, new_mode, cur_slot, new_slot;
    logic              has_saved;
    logic              arb_valid;
    exc_e              arb_kind;
    logic              accept, do_ret, commit, stat_wr, reg_we;
    logic [DATA_W-1:0] entry_status, lr_val, link_next;

    logic [NRD-1:0][ADDR_W-1:0] x_addr;
    logic [NRD-1:0][PHYS_W-1:0] x_idx;
    logic [NRD-1:0][DATA_W-1:0] x_data;
    logic [PHYS_W-1:0]          w_idx, l_idx;

    assign cur_mode  = status_q[2:0];
    assign new_mode  = exc_target_mode(kind_q);
    assign cur_slot  = cur_mode - 3'd1;
    assign new_slot  = new_mode - 3'd1;
    assign has_saved = (cur_mode >= MD_FIQ) && (cur_mode <= MD_UND);

    exc_arbiter u_arb (
        .req      (exc_req),
        .irq_mask (status_q[BIT_IMASK]),
        .fiq_mask (status_q[BIT_FMASK]),
        .valid    (arb_valid),
        .kind     (arb_kind)
    );

    // bank translation: port A, port B, current-mode link register
    assign x_addr[0]       = rd_addr_a;
    assign x_addr[1]       = rd_addr_b;
    assign x_addr[LR_PORT] = ADDR_W'(LR_ADDR);

    for (genvar g = 0; g < NRD; g++) begin : g_xr
        bank_xlate u_xr (
            .mode (cur_mode),
            .addr (x_addr[g]),
            .idx  (x_idx[g])
        );
    end

    bank_xlate u_xw (
        .mode (cur_mode),
        .addr (wr_addr),
        .idx  (w_idx)
    );

    bank_xlate u_xl (
        .mode (new_mode),
        .addr (ADDR_W'(LR_ADDR)),
        .idx  (l_idx)
    );

    phys_store #(.DATA_W(DATA_W), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (x_idx),
        .rd_data (x_data),
        .we_a    (reg_we),
        .wa_idx  (w_idx),
        .wd_a    (wr_data),
        .we_b    (commit),
        .wb_idx  (l_idx),
        .wd_b    (link_q)
    );

    assign lr_val    = x_data[LR_PORT];
    assign reg_we    = wr_en && (wr_addr != ADDR_W'(PC_ADDR));
    assign rd_data_a = (rd_addr_a == ADDR_W'(PC_ADDR)) ? pc_q : x_data[0];
    assign rd_data_b = (rd_addr_b == ADDR_W'(PC_ADDR)) ? pc_q : x_data[1];
    assign link_next = pc_q + (exc_pc_advanced(arb_kind) ? DATA_W'(8) : DATA_W'(4));

    always_comb begin
        entry_status = status_q;
        entry_status[2:0] = new_mode;
        entry_status[BIT_IMASK] = 1'b1;
        if (kind_q == EX_FIQ) entry_status[BIT_FMASK] = 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (arb_valid) state_d = ST_TAKE;
            ST_TAKE: state_d = ST_RUN;
        endcase
    end

    // output strobes of the sequencer
    always_comb begin
        accept  = 1'b0;
        do_ret  = 1'b0;
        stat_wr = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                accept  = arb_valid;
                do_ret  = !arb_valid && exc_ret && has_saved;
                stat_wr = !arb_valid && !do_ret && status_wr_en;
            end
            ST_TAKE: commit = 1'b1;
        endcase
    end

    // program counter, status, saved status, entry latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q     <= '0;
            status_q <= RESET_STATUS;
            link_q   <= '0;
            kind_q   <= EX_RESET;
            for (int i = 0; i < SAVED_N; i++) saved_q[i] <= '0;
        end else begin
            if (accept) begin
                kind_q <= arb_kind;
                link_q <= link_next;
            end

            if (commit)
                pc_q <= DATA_W'({kind_q, 2'b00});
            else if (accept)
                pc_q <= pc_q;
            else if (do_ret)
                pc_q <= lr_val - (DATA_W'(ret_words) << 2);
            else if (wr_en && wr_addr == ADDR_W'(PC_ADDR))
                pc_q <= wr_data;
            else if (pc_step)
                pc_q <= pc_q + DATA_W'(4);

            if (commit) begin
                saved_q[new_slot] <= status_q;
                status_q <= entry_status;
            end else if (do_ret) begin
                status_q <= saved_status_out;
            end else if (stat_wr) begin
                status_q <= status_wr_data;
            end
        end
    end

    assign pc_out           = pc_q;
    assign status_out       = status_q;
    assign saved_status_out = has_saved ? saved_q[cur_slot] : '0;
endmodule

// File: rtl/bankrf_checker.sv
module bankrf_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_take,
    input logic              take_is_fiq,
    input logic              accept,
    input logic              exc_ret,
    input logic              status_wr_en,
    input logic [DATA_W-1:0] pc_out,
    input logic [DATA_W-1:0] status_out,
    input logic [DATA_W-1:0] saved_status_out
);
    // R6
    vector_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_take |=> ((pc_out >> 5) == '0) && (pc_out[1:0] == 2'b00));

    // R6
    take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_take |=> !in_take);

    // R7
    saved_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_take |=> saved_status_out == $past(status_out));

    // R7
    fiq_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_take && take_is_fiq) |=> (status_out[7] && status_out[6]));

    // R11
    accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> $stable(pc_out));

    // R10
    user_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_take && !accept && exc_ret && !status_wr_en && status_out[2:0] == 3'd0)
        |=> $stable(status_out));
endmodule

bind mode_banked_regfile bankrf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_take          (state_q == ST_TAKE),
    .take_is_fiq      (kind_q == EX_FIQ),
    .accept           (accept),
    .exc_ret          (exc_ret),
    .status_wr_en     (status_wr_en),
    .pc_out           (pc_out),
    .status_out       (status_out),
    .saved_status_out (saved_status_out)
);

// File: tb/tb_mode_banked_regfile.sv
module tb_mode_banked_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [31:0] rd_data_a, rd_data_b, wr_data;
    logic        wr_en, pc_step, status_wr_en, exc_ret;
    logic [31:0] status_wr_data;
    logic [7:0]  exc_req;
    logic [1:0]  ret_words;
    logic [31:0] pc_out, status_out, saved_status_out;

    int n_run  = 0;
    int n_fail = 0;

    // model state
    logic [31:0] m_usr [15];
    logic [31:0] m_fiq [7];
    logic [31:0] m_pair [4][2];
    logic [31:0] m_saved [5];
    logic [31:0] m_pc, m_st, m_link;
    int          m_take, m_kind;

    always #10 clk = ~clk;

    mode_banked_regfile dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input int md, input int a);
        if (a == 15) return m_pc;
        if (md == 1 && a >= 8) return m_fiq[a-8];
        if (md >= 2 && md <= 5 && a >= 13) return m_pair[md-2][a-13];
        return m_usr[a];
    endfunction

    task automatic mwrite(input int md, input int a, input logic [31:0] d);
        if (md == 1 && a >= 8) m_fiq[a-8] = d;
        else if (md >= 2 && md <= 5 && a >= 13) m_pair[md-2][a-13] = d;
        else m_usr[a] = d;
    endtask

    function automatic int kind_mode(input int k);
        case (k)
            1: return 5;
            3, 4: return 4;
            6: return 2;
            7: return 1;
            default: return 3;
        endcase
    endfunction

    // winner per priority list, -1 if none
    function automatic int pick(input logic [7:0] rq, input logic [31:0] st);
        int ord [7] = '{0, 4, 7, 6, 3, 1, 2};
        for (int i = 0; i < 7; i++) begin
            int b = ord[i];
            if (rq[b] && !(b == 6 && st[7]) && !(b == 7 && st[6])) return b;
        end
        return -1;
    endfunction

    function automatic logic [31:0] msaved();
        int md = int'(m_st[2:0]);
        return (md >= 1 && md <= 5) ? m_saved[md-1] : 32'h0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 15; i++) m_usr[i] = 0;
        for (int i = 0; i < 7; i++) m_fiq[i] = 0;
        for (int i = 0; i < 4; i++) begin m_pair[i][0] = 0; m_pair[i][1] = 0; end
        for (int i = 0; i < 5; i++) m_saved[i] = 0;
        m_pc = 0; m_st = 32'hC3; m_take = 0; m_kind = 0; m_link = 0;
    endtask

    task automatic model_update();
        int md = int'(m_st[2:0]);
        int k;
        logic [31:0] lr, ns;
        if (m_take == 0) begin
            k = pick(exc_req, m_st);
            if (k >= 0) begin
                if (wr_en && wr_addr != 15) mwrite(md, int'(wr_addr), wr_data);
                m_take = 1; m_kind = k;
                m_link = m_pc + ((k == 6 || k == 7 || k == 4) ? 32'd8 : 32'd4);
            end else if (exc_ret && md >= 1 && md <= 5) begin
                lr = mread(md, 14);
                ns = m_saved[md-1];
                if (wr_en && wr_addr != 15) mwrite(md, int'(wr_addr), wr_data);
                m_pc = lr - 32'(ret_words) * 4;
                m_st = ns;
            end else begin
                if (wr_en && wr_addr != 15) mwrite(md, int'(wr_addr), wr_data);
                if (wr_en && wr_addr == 15) m_pc = wr_data;
                else if (pc_step) m_pc = m_pc + 4;
                if (status_wr_en) m_st = status_wr_data;
            end
        end else begin
            int nm = kind_mode(m_kind);
            if (wr_en && wr_addr != 15) mwrite(md, int'(wr_addr), wr_data);
            m_saved[nm-1] = m_st;
            ns = m_st;
            ns[2:0] = 3'(nm);
            ns[7] = 1'b1;
            if (m_kind == 7) ns[6] = 1'b1;
            m_st = ns;
            mwrite(nm, 14, m_link);
            m_pc = 32'(m_kind) * 4;
            m_take = 0;
        end
    endtask

    task automatic idle();
        wr_en = 0; pc_step = 0; status_wr_en = 0; exc_req = 0; exc_ret = 0; ret_words = 0;
    endtask

    // compare, clock, update model; returns at the next falling edge
    task automatic step();
        #1;
        check("R2 read port A", rd_data_a, mread(int'(m_st[2:0]), int'(rd_addr_a)));
        check("R2 read port B", rd_data_b, mread(int'(m_st[2:0]), int'(rd_addr_b)));
        check("R11 pc", pc_out, m_pc);
        check("R12 status", status_out, m_st);
        check("R7 saved status", saved_status_out, msaved());
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, input string tag, input logic [31:0] exp);
        rd_addr_a = a;
        #1;
        check(tag, rd_data_a, exp);
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic set_status(input logic [31:0] d);
        status_wr_en = 1; status_wr_data = d;
        step();
        status_wr_en = 0;
    endtask

    task automatic do_return(input logic [1:0] w);
        exc_ret = 1; ret_words = w;
        step();
        exc_ret = 0; ret_words = 0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] x;
        void'($urandom(32'd4242));
        rst_n = 0; idle();
        rd_addr_a = 0; rd_addr_b = 0; wr_addr = 0; wr_data = 0; status_wr_data = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        check("R1 pc", pc_out, 32'h0);
        check("R1 status", status_out, 32'hC3);
        check("R1 saved", saved_status_out, 32'h0);
        for (int i = 0; i < 15; i++) rd(4'(i), "R1 register", 32'h0);

        // R12 status write to user mode, unmasked
        set_status(32'h0);
        check("R12 status write", status_out, 32'h0);
        wreg(4'd8, 32'h11); wreg(4'd13, 32'h22); wreg(4'd14, 32'h33); wreg(4'd0, 32'h44);

        // FIQ entry: R3 R6 R7 R8
        x = m_pc;
        exc_req = 8'h80; step(); exc_req = 0; step();
        check("R6 fiq vector", pc_out, 32'h1C);
        check("R6 fiq mode", {29'h0, status_out[2:0]}, 32'd1);
        check("R7 fiq masks", {30'h0, status_out[7:6]}, 32'd3);
        check("R7 fiq saved", saved_status_out, 32'h0);
        rd(4'd14, "R8 fiq link", x + 8);
        rd(4'd8, "R3 fiq private r8", 32'h0);
        rd(4'd0, "R3 fiq shared r0", 32'h44);
        wreg(4'd8, 32'h99);
        // R10 return with one word
        do_return(2'd1);
        check("R10 fiq return pc", pc_out, x + 4);
        check("R10 fiq return status", status_out, 32'h0);
        rd(4'd8, "R10 restored bank r8", 32'h11);

        // IRQ with write during commit: R4 R5
        x = m_pc;
        exc_req = 8'h40; step(); exc_req = 0;
        wr_en = 1; wr_addr = 4'd13; wr_data = 32'h55; step(); wr_en = 0;
        check("R6 irq vector", pc_out, 32'h18);
        rd(4'd13, "R5 irq r13 untouched", 32'h0);
        rd(4'd8, "R4 irq shared r8", 32'h11);
        rd(4'd14, "R8 irq link", x + 8);
        do_return(2'd1);
        rd(4'd13, "R5 write went to old bank", 32'h55);
        check("R10 irq return pc", pc_out, x + 4);

        // R9 priority: FIQ, IRQ, data abort, SWI together
        x = m_pc;
        exc_req = 8'hD4; step(); exc_req = 0; step();
        check("R9 dabt wins vector", pc_out, 32'h10);
        check("R9 dabt wins mode", {29'h0, status_out[2:0]}, 32'd4);
        rd(4'd14, "R8 dabt link", x + 8);
        do_return(2'd2);
        check("R10 dabt retry pc", pc_out, x);

        // R9 masked IRQ and reserved bit
        set_status(32'h80);
        x = m_pc;
        exc_req = 8'h40; step(); exc_req = 8'h20; step(); exc_req = 0; step();
        check("R9 masked irq ignored", pc_out, x);
        check("R9 masked irq mode", status_out, 32'h80);
        set_status(32'h0);

        // SWI link +4, return with no adjustment
        x = m_pc;
        exc_req = 8'h04; step(); exc_req = 0; step();
        check("R6 swi vector", pc_out, 32'h08);
        rd(4'd14, "R8 swi link", x + 4);
        do_return(2'd0);
        check("R10 swi return pc", pc_out, x + 4);

        // reset request beats FIQ
        exc_req = 8'h81; step(); exc_req = 0; step();
        check("R9 reset wins", pc_out, 32'h0);
        check("R9 reset mode", {29'h0, status_out[2:0]}, 32'd3);
        do_return(2'd1);

        // R10 return in user mode ignored
        x = m_pc;
        exc_ret = 1; pc_step = 1; step(); exc_ret = 0; pc_step = 0;
        check("R10 user return ignored status", status_out, 32'h0);
        check("R10 user return ignored pc", pc_out, x + 4);

        // R11 pc write, step, hold on accept
        wreg(4'd15, 32'h1000);
        check("R11 pc write", pc_out, 32'h1000);
        pc_step = 1; step();
        check("R11 pc step", pc_out, 32'h1004);
        exc_req = 8'h02; step(); exc_req = 0; pc_step = 0;
        check("R11 pc held on accept", pc_out, 32'h1004);
        step();
        check("R6 undef vector", pc_out, 32'h04);
        do_return(2'd0);

        // constrained random
        for (int c = 0; c < 4000; c++) begin
            logic [31:0] sd;
            wr_en   = 1'($urandom % 2);
            wr_addr = ($urandom % 10 == 0) ? 4'd15 : 4'($urandom % 15);
            wr_data = $urandom;
            rd_addr_a = 4'($urandom % 16);
            rd_addr_b = 4'($urandom % 16);
            pc_step = 1'($urandom % 2);
            status_wr_en = ($urandom % 20 == 0);
            sd = $urandom;
            sd[2:0] = 3'($urandom % 6);
            status_wr_data = sd;
            exc_req = ($urandom % 8 == 0) ? 8'($urandom) : 8'h0;
            exc_ret = ($urandom % 10 == 0);
            ret_words = 2'($urandom % 4);
            step();
        end
        idle();
        step();

        summary();
        $finish;
    end
endmodule